// File: doc/BRIEF.md
# Serial Modulo-3 Remainder Tracker

This block takes in a binary number one bit per clock, most significant bit first, and keeps the remainder modulo 3 of the value received so far. It does not store the number or count its bits. Instead it holds a three-valued state and updates it by the rule rem' = (2*rem + bit) mod 3. Because of this, streams of any length are handled, and the block does not need to know the stream length in advance.

A valid strobe marks the cycles that carry a data bit. In every other cycle the remainder is held. A synchronous active-low reset restarts the tracker for a new number. The current remainder is visible at the output at all times, and a separate flag reports when the value seen so far is a multiple of 3.

Top module: `mod3_serial_tracker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the remainder becomes 0 after that edge, and `div_o` is then 1.
- R2: At an edge where `rst_n` is high, `bit_vld` is 1 and `bit_in` is 0, the remainder moves 0→0, 1→2, 2→1.
- R3: At an edge where `rst_n` is high, `bit_vld` is 1 and `bit_in` is 1, the remainder moves 0→1, 1→0, 2→2.
- R4: `rem_o` shows remainder 0 as 2'b00, 1 as 2'b01 and 2 as 2'b10. The code 2'b11 never appears, and if the state ever holds it, the next update returns it to 0.
- R5: At an edge where `bit_vld` is 0, the remainder keeps its value whatever `bit_in` is.
- R6: `div_o` is 1 in exactly the cycles where `rem_o` is 2'b00. It follows the state in the same cycle, with no extra register.
- R7: After any number of valid bits since the last reset, `rem_o` equals the value of those bits, read MSB first, modulo 3.
- R8: Reset takes priority over a valid bit presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset / clear to remainder 0 |
| bit_vld | input | 1 | High when `bit_in` carries the next bit of the number |
| bit_in | input | 1 | Serial data bit, most significant first |
| rem_o | output | 2 | Current remainder modulo 3 (00, 01, 10) |
| div_o | output | 1 | High when the value so far is divisible by 3 |

## Verification
The hardest cases to reach from the ports are long runs that sit in the middle state, and inputs that arrive while the strobe is low and must be ignored. Both carry forward a specific remainder that a short stream seldom produces. The stimulus therefore streams random numbers of random length, from 1 to 64 bits, and scatters idle cycles with random data between the valid bits. After every bit, a bench model that doubles and adds predicts the remainder, and at the end of each number the result is compared with the whole number reduced modulo 3. Directed steps first walk all six transitions one at a time, then test a reset that arrives together with a valid bit.

// File: rtl/mod3_pkg.sv
// Package: shared types for the serial modulo-3 tracker.
// Assumes the remainder is always one of three legal codes; 2'b11 is unused.
package mod3_pkg;
    localparam int REM_W = 2;

    typedef enum logic [REM_W-1:0] {
        REM0 = 2'b00,
        REM1 = 2'b01,
        REM2 = 2'b10
    } rem_t;
endpackage

// File: rtl/mod3_step.sv
// Module: mod3_step
// Computes the next remainder (2*cur + din) mod 3 for one serial bit.
// Assumes cur holds a legal code; any illegal code maps to REM0.
module mod3_step
    import mod3_pkg::*;
(
    input  rem_t cur,
    input  logic din,
    output rem_t nxt
);
    // Purpose: double-and-add transition table, reduced modulo 3.
    always_comb begin
        case (cur)
            REM0:    nxt = din ? REM1 : REM0;
            REM1:    nxt = din ? REM0 : REM2;
            REM2:    nxt = din ? REM2 : REM1;
            default: nxt = REM0;
        endcase
    end
endmodule

// File: rtl/mod3_state_reg.sv
// Module: mod3_state_reg
// Holds the remainder; loads d when adv is high, clears on low rst_n.
// Assumes rst_n is synchronous to clk and has priority over adv.
module mod3_state_reg
    import mod3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  rem_t d,
    output rem_t q
);
    // Purpose: synchronous clear, otherwise advance only on a valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= REM0;
        end else if (adv) begin
            q <= d;
        end
    end
endmodule

// File: rtl/mod3_zero_flag.sv
// Module: mod3_zero_flag
// Decodes the divisible-by-3 flag from the remainder state, combinationally.
// Assumes cur is a legal code.
module mod3_zero_flag
    import mod3_pkg::*;
(
    input  rem_t cur,
    output logic is_zero
);
    // Purpose: flag high whenever the remainder equals zero.
    always_comb begin
        is_zero = (cur == REM0);
    end
endmodule

// File: rtl/mod3_serial_tracker.sv
// Module: mod3_serial_tracker (top)
// Tracks, bit by bit, an MSB-first binary number modulo 3.
// Assumes one bit per cycle in which bit_vld is high; the stream length is unbounded.
module mod3_serial_tracker
    import mod3_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [REM_W-1:0] rem_o,
    output logic             div_o
);
    rem_t rem_q;
    rem_t rem_d;

    mod3_step u_step (
        .cur (rem_q),
        .din (bit_in),
        .nxt (rem_d)
    );

    mod3_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (bit_vld),
        .d     (rem_d),
        .q     (rem_q)
    );

    mod3_zero_flag u_flag (
        .cur     (rem_q),
        .is_zero (div_o)
    );

    // Purpose: expose the remainder code at the port.
    always_comb begin
        rem_o = rem_q;
    end
endmodule

// File: rtl/mod3_serial_tracker_chk.sv
// Module: mod3_serial_tracker_chk
// Checker for the tracker's port behaviour; bound to the top module below.
// Assumes a synchronous active-low reset.
module mod3_serial_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_vld,
    input logic       bit_in,
    input logic [1:0] rem_o,
    input logic       div_o
);
    // R1: the cycle after a reset edge shows remainder 0
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0) |-> (rem_o == 2'b00));

    // R2: valid zero bit maps 0->0, 1->2, 2->1
    a_r2_zero_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !bit_in) |=> (rem_o == (($past(rem_o) == 2'b01) ? 2'b10 :
                                            ($past(rem_o) == 2'b10) ? 2'b01 : 2'b00)));

    // R3: valid one bit maps 0->1, 1->0, 2->2
    a_r3_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_in) |=> (rem_o == (($past(rem_o) == 2'b00) ? 2'b01 :
                                           ($past(rem_o) == 2'b10) ? 2'b10 : 2'b00)));

    // R4: unused code never shows
    a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        rem_o != 2'b11);

    // R5: no valid bit, no change
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(rem_o));

    // R6: flag agrees with the remainder
    a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
        div_o == (rem_o == 2'b00));
endmodule

bind mod3_serial_tracker mod3_serial_tracker_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .rem_o   (rem_o),
    .div_o   (div_o)
);

// File: tb/mod3_serial_tracker_test.sv
// Bench: random MSB-first numbers plus directed transitions, checked against a bench model.
module mod3_serial_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic [1:0] rem_o;
    logic       div_o;

    int checks = 0;
    int errors = 0;
    int exp_rem = 0;

    always #2 clk = ~clk;   // 250 MHz

    mod3_serial_tracker uut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .rem_o(rem_o), .div_o(div_o)
    );

    function automatic int model_step(int r, logic b);
        return (2 * r + int'(b)) % 3;
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Drive one cycle at the falling edge, then sample just after the rising edge.
    task automatic cycle(logic rn, logic v, logic b);
        @(negedge clk);
        rst_n = rn; bit_vld = v; bit_in = b;
        @(posedge clk);
        #1;
        if (!rn) exp_rem = 0;
        else if (v) exp_rem = model_step(exp_rem, b);
    endtask

    task automatic check_state(string req);
        check(req, int'(rem_o), exp_rem);
        check("R6", int'(div_o), (exp_rem == 0) ? 1 : 0);
        check("R4", (rem_o == 2'b11) ? 1 : 0, 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2015));
        // R1: reset state
        cycle(1'b0, 1'b0, 1'b0);
        cycle(1'b0, 1'b1, 1'b1);
        check_state("R1");

        // R3 then R2: walk all six transitions, reaching states 1 and 2
        cycle(1'b1, 1'b1, 1'b0); check_state("R2 0->0");
        cycle(1'b1, 1'b1, 1'b1); check_state("R3 0->1");
        cycle(1'b1, 1'b1, 1'b0); check_state("R2 1->2");
        cycle(1'b1, 1'b1, 1'b1); check_state("R3 2->2");
        cycle(1'b1, 1'b1, 1'b0); check_state("R2 2->1");
        cycle(1'b1, 1'b1, 1'b1); check_state("R3 1->0");
        cycle(1'b1, 1'b1, 1'b1); check_state("R3 0->1");
        cycle(1'b1, 1'b1, 1'b0); check_state("R2 1->2");
        check("R2", int'(rem_o), 2);

        // R5: strobe low with toggling data holds the remainder at 2
        for (int i = 0; i < 4; i++) begin
            cycle(1'b1, 1'b0, i[0]);
            check_state("R5");
            check("R5", int'(rem_o), 2);
        end

        // R8: reset with a valid bit in the same cycle
        cycle(1'b0, 1'b1, 1'b1);
        check("R8", int'(rem_o), 0);

        // R7: random numbers of random length, idle gaps mixed in
        for (int n = 0; n < 300; n++) begin
            int unsigned len;
            logic [63:0] val;
            cycle(1'b0, 1'b0, 1'b0);
            len = 1 + ($urandom % 64);
            val = {$urandom, $urandom};
            if (len < 64) val = val & ((64'd1 << len) - 64'd1);
            if (n == 0) begin len = 64; val = '1; end
            if (n == 1) begin len = 40; val = 64'd0; end
            for (int k = int'(len) - 1; k >= 0; k--) begin
                if ($urandom % 4 == 0) begin
                    cycle(1'b1, 1'b0, 1'($urandom));
                    check_state("R5");
                end
                cycle(1'b1, 1'b1, val[k]);
                check_state("R7");
            end
            check("R7", int'(rem_o), int'(val % 64'd3));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule